// File: doc/BRIEF.md
# Paired-Page Translation Lookaside Buffer

This block is a small, fully associative translation cache. Every cycle it may receive a lookup made of a virtual page number, an address-space identifier and a requested access mask. It compares the lookup against all entries at once and returns a registered result one cycle later. A hit returns the physical page number and the permission bits. A hit whose permissions do not cover the requested access also raises a protection fault. A miss raises a one-cycle walk request that carries the virtual page number and identifier, so that an external page table walker can service it.

Each entry holds one tag for an aligned pair of neighbouring virtual pages. The tag is the virtual page number without its lowest bit. That lowest bit selects one of two independent translations, each with its own valid bit, physical page number and permission bits. Entries also carry an address-space identifier, so translations of several processes can live side by side. A global flush empties the whole buffer, and a selective flush empties only the entries of one identifier.

The walker answers through a fill port. A fill first merges into an existing entry with the same pair tag and identifier. If there is none, it takes the lowest-numbered empty entry, and when no entry is empty it replaces the entry named by a round-robin pointer.

Top module: `pair_tlb`

## Requirements
- R1: While reset is high and on the first cycle after it, rs_valid and wk_req are 0, and every entry is empty, so the first lookup after reset misses.
- R2: rs_valid is high exactly one cycle after a cycle with lk_valid high, and the result describes that lookup.
- R3: A hit returns rs_hit=1 together with the physical page number and permission bits of the half that lk_vpn bit 0 selects: 0 selects the even page and 1 the odd page.
- R4: A miss returns rs_hit=0, rs_ppn=0 and rs_perm=0, and raises wk_req for that one cycle with wk_vpn and wk_asid equal to the looked-up values.
- R5: A translation hits only if the identifier stored with it equals lk_asid.
- R6: The permission and access bits are bit 0 read, bit 1 write and bit 2 execute. rs_fault is 1 exactly when there is a hit and some bit set in lk_acc is clear in the returned permissions.
- R7: A fill whose pair tag and identifier match a valid entry updates only the selected half and keeps the other half. A fill that creates a new entry marks the other half of that entry invalid.
- R8: A new entry goes into the lowest-numbered empty entry. When every entry is in use, the victim is picked by a pointer that starts at entry 0 after reset and steps up by one, wrapping around, on each such replacement.
- R9: flush_all empties every entry, and a lookup in the next cycle misses.
- R10: flush_asid_en empties only the entries whose identifier equals flush_asid. Entries of other identifiers still hit.
- R11: A fill in a cycle with any flush is dropped. A lookup in the same cycle as a fill or flush sees the contents from before that cycle.
- R12: At most one entry hits any lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_asid | input | ASID_W | Identifier of the requesting address space |
| lk_acc | input | 3 | Requested access mask (bit 0 read, bit 1 write, bit 2 execute) |
| fl_valid | input | 1 | Fill from the walker this cycle |
| fl_vpn | input | VPN_W | Virtual page number of the fill |
| fl_asid | input | ASID_W | Identifier of the fill |
| fl_ppn | input | PPN_W | Physical page number of the fill |
| fl_perm | input | 3 | Permission bits of the fill |
| flush_all | input | 1 | Empty every entry |
| flush_asid_en | input | 1 | Empty the entries of one identifier |
| flush_asid | input | ASID_W | Identifier for the selective flush |
| rs_valid | output | 1 | Result of the previous cycle's lookup is present |
| rs_hit | output | 1 | Lookup hit |
| rs_fault | output | 1 | Hit with insufficient permission |
| rs_ppn | output | PPN_W | Translated physical page number |
| rs_perm | output | 3 | Permission bits of the hit |
| wk_req | output | 1 | Walk request for a missed lookup |
| wk_vpn | output | VPN_W | Virtual page number to walk |
| wk_asid | output | ASID_W | Identifier to walk |

## Verification
Every lookup result, including the fault flag and the walk request, is due in the cycle after the lookup is driven. A fill or flush changes what a lookup driven in the next cycle returns, and does not affect a lookup in the same cycle. The bench drives all inputs just after a rising edge. Before that edge it works out the expected result from its own model of the entries, then applies the fill or flush to the model. It compares the outputs shortly after the edge, so same-cycle lookup and fill pairs are checked against the contents from before the edge.

// File: rtl/pair_tlb_pkg.sv
`timescale 1ns/1ps
package pair_tlb_pkg;
  localparam int PERM_W = 3;
  // bit 0 read, bit 1 write, bit 2 execute
  typedef logic [PERM_W-1:0] perm_t;
  localparam int HALVES = 2;
endpackage

// File: rtl/pair_tlb_enc.sv
`timescale 1ns/1ps
// Lowest-index-first encoder of a request vector.
module pair_tlb_enc #(
  parameter int N  = 16,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    idx = '0;
    any = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        idx = IW'(i);
        any = 1'b1;
      end
    end
  end
endmodule

// File: rtl/pair_tlb_match.sv
`timescale 1ns/1ps
// Parallel comparison of one key against every entry.
module pair_tlb_match #(
  parameter int ENTRIES = 16,
  parameter int TAG_W   = 19,
  parameter int ASID_W  = 4
) (
  input  logic [ENTRIES-1:0][TAG_W-1:0]  tag_q,
  input  logic [ENTRIES-1:0][ASID_W-1:0] asid_q,
  input  logic [ENTRIES-1:0][1:0]        hv_q,
  input  logic [TAG_W-1:0]               key_tag,
  input  logic [ASID_W-1:0]              key_asid,
  input  logic                           key_half,
  output logic [ENTRIES-1:0]             hit_vec,
  output logic [ENTRIES-1:0]             pair_vec
);
  logic [ENTRIES-1:0] same;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    assign same[e]     = (tag_q[e] == key_tag) && (asid_q[e] == key_asid);
    assign pair_vec[e] = same[e] && (|hv_q[e]);
    assign hit_vec[e]  = same[e] && hv_q[e][key_half];
  end
endmodule

// File: rtl/pair_tlb_victim.sv
`timescale 1ns/1ps
// Picks the entry a new pair goes into: lowest empty one, else round robin.
module pair_tlb_victim #(
  parameter int ENTRIES = 16,
  parameter int IW      = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ENTRIES-1:0] free_vec,
  input  logic               alloc,
  output logic [IW-1:0]      victim
);
  localparam logic [IW-1:0] LAST = IW'(ENTRIES - 1);

  logic [IW-1:0] rr_q;
  logic [IW-1:0] free_idx;
  logic          free_any;

  pair_tlb_enc #(.N(ENTRIES), .IW(IW)) u_free (
    .vec (free_vec),
    .idx (free_idx),
    .any (free_any)
  );

  assign victim = free_any ? free_idx : rr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rr_q <= '0;
    end else if (alloc && !free_any) begin
      rr_q <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
    end
  end
endmodule

// File: rtl/pair_tlb.sv
`timescale 1ns/1ps
module pair_tlb
  import pair_tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 12,
  parameter int ASID_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic [2:0]        lk_acc,
  input  logic              fl_valid,
  input  logic [VPN_W-1:0]  fl_vpn,
  input  logic [ASID_W-1:0] fl_asid,
  input  logic [PPN_W-1:0]  fl_ppn,
  input  logic [2:0]        fl_perm,
  input  logic              flush_all,
  input  logic              flush_asid_en,
  input  logic [ASID_W-1:0] flush_asid,
  output logic              rs_valid,
  output logic              rs_hit,
  output logic              rs_fault,
  output logic [PPN_W-1:0]  rs_ppn,
  output logic [2:0]        rs_perm,
  output logic              wk_req,
  output logic [VPN_W-1:0]  wk_vpn,
  output logic [ASID_W-1:0] wk_asid
);
  localparam int TAG_W = VPN_W - 1;
  localparam int IW    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  // entry storage
  logic [ENTRIES-1:0][TAG_W-1:0]         tag_q;
  logic [ENTRIES-1:0][ASID_W-1:0]        asid_q;
  logic [ENTRIES-1:0][1:0]               hv_q;
  logic [ENTRIES-1:0][1:0][PPN_W-1:0]    ppn_q;
  logic [ENTRIES-1:0][1:0][PERM_W-1:0]   perm_q;

  // lookup side
  logic [ENTRIES-1:0] lk_hit_vec;
  logic [ENTRIES-1:0] lk_pair_vec;
  logic [IW-1:0]      lk_idx;
  logic               lk_any;
  logic               lk_half;
  logic [PPN_W-1:0]   lk_ppn;
  perm_t              lk_perm;

  // fill side
  logic [ENTRIES-1:0] fl_hit_vec;
  logic [ENTRIES-1:0] fl_pair_vec;
  logic [IW-1:0]      fl_pair_idx;
  logic               fl_pair_any;
  logic [IW-1:0]      fl_victim;
  logic [IW-1:0]      fl_idx;
  logic               fl_half;
  logic               fl_take;
  logic               fl_alloc;
  logic [ENTRIES-1:0] free_vec;

  assign lk_half = lk_vpn[0];
  assign fl_half = fl_vpn[0];

  pair_tlb_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .ASID_W(ASID_W)) u_lk_match (
    .tag_q    (tag_q),
    .asid_q   (asid_q),
    .hv_q     (hv_q),
    .key_tag  (lk_vpn[VPN_W-1:1]),
    .key_asid (lk_asid),
    .key_half (lk_half),
    .hit_vec  (lk_hit_vec),
    .pair_vec (lk_pair_vec)
  );

  pair_tlb_enc #(.N(ENTRIES), .IW(IW)) u_lk_enc (
    .vec (lk_hit_vec),
    .idx (lk_idx),
    .any (lk_any)
  );

  pair_tlb_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .ASID_W(ASID_W)) u_fl_match (
    .tag_q    (tag_q),
    .asid_q   (asid_q),
    .hv_q     (hv_q),
    .key_tag  (fl_vpn[VPN_W-1:1]),
    .key_asid (fl_asid),
    .key_half (fl_half),
    .hit_vec  (fl_hit_vec),
    .pair_vec (fl_pair_vec)
  );

  pair_tlb_enc #(.N(ENTRIES), .IW(IW)) u_fl_enc (
    .vec (fl_pair_vec),
    .idx (fl_pair_idx),
    .any (fl_pair_any)
  );

  for (genvar e = 0; e < ENTRIES; e++) begin : g_free
    assign free_vec[e] = ~|hv_q[e];
  end

  assign fl_take  = fl_valid && !flush_all && !flush_asid_en;
  assign fl_alloc = fl_take && !fl_pair_any;
  assign fl_idx   = fl_pair_any ? fl_pair_idx : fl_victim;

  pair_tlb_victim #(.ENTRIES(ENTRIES), .IW(IW)) u_victim (
    .clk      (clk),
    .rst      (rst),
    .free_vec (free_vec),
    .alloc    (fl_alloc),
    .victim   (fl_victim)
  );

  // read mux for the hitting entry
  assign lk_ppn  = ppn_q[lk_idx][lk_half];
  assign lk_perm = perm_q[lk_idx][lk_half];

  // valid bits: reset, flushes and fills
  always_ff @(posedge clk) begin
    if (rst) begin
      hv_q <= '0;
    end else if (flush_all) begin
      hv_q <= '0;
    end else if (flush_asid_en) begin
      for (int e = 0; e < ENTRIES; e++) begin
        if (asid_q[e] == flush_asid) begin
          hv_q[e] <= 2'b00;
        end
      end
    end else if (fl_valid) begin
      hv_q[fl_idx][fl_half] <= 1'b1;
      if (!fl_pair_any) begin
        hv_q[fl_idx][!fl_half] <= 1'b0;
      end
    end
  end

  // payload storage, no reset so it can map to plain memory bits
  always_ff @(posedge clk) begin
    if (fl_take) begin
      tag_q[fl_idx]           <= fl_vpn[VPN_W-1:1];
      asid_q[fl_idx]          <= fl_asid;
      ppn_q[fl_idx][fl_half]  <= fl_ppn;
      perm_q[fl_idx][fl_half] <= fl_perm;
    end
  end

  // registered result
  always_ff @(posedge clk) begin
    if (rst) begin
      rs_valid <= 1'b0;
      rs_hit   <= 1'b0;
      rs_fault <= 1'b0;
      rs_ppn   <= '0;
      rs_perm  <= '0;
      wk_req   <= 1'b0;
      wk_vpn   <= '0;
      wk_asid  <= '0;
    end else begin
      rs_valid <= lk_valid;
      rs_hit   <= lk_valid && lk_any;
      rs_fault <= lk_valid && lk_any && (|(lk_acc & ~lk_perm));
      rs_ppn   <= (lk_valid && lk_any) ? lk_ppn : '0;
      rs_perm  <= (lk_valid && lk_any) ? lk_perm : '0;
      wk_req   <= lk_valid && !lk_any;
      wk_vpn   <= lk_vpn;
      wk_asid  <= lk_asid;
    end
  end
endmodule

// File: rtl/pair_tlb_chk.sv
`timescale 1ns/1ps
module pair_tlb_chk #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    lk_valid,
  input logic [VPN_W-1:0]        lk_vpn,
  input logic [2:0]              lk_acc,
  input logic                    flush_all,
  input logic                    rs_valid,
  input logic                    rs_hit,
  input logic                    rs_fault,
  input logic [2:0]              rs_perm,
  input logic                    wk_req,
  input logic [VPN_W-1:0]        wk_vpn,
  input logic [ENTRIES-1:0]      hit_vec,
  input logic [ENTRIES-1:0][1:0] hv_all
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!rs_valid && !wk_req));

  p_result_follows_r2: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> rs_valid);

  p_no_result_r2: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !rs_valid);

  p_walk_on_miss_r4: assert property (@(posedge clk) disable iff (rst)
    wk_req |-> (rs_valid && !rs_hit));

  p_walk_vpn_r4: assert property (@(posedge clk) disable iff (rst)
    wk_req |-> (wk_vpn == $past(lk_vpn)));

  p_fault_rule_r6: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> (rs_fault == (rs_hit && ((~rs_perm & $past(lk_acc)) != 3'b000))));

  p_flush_empties_r9: assert property (@(posedge clk) disable iff (rst)
    flush_all |=> (hv_all == '0));

  p_single_hit_r12: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec));
endmodule

bind pair_tlb pair_tlb_chk #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .lk_valid  (lk_valid),
  .lk_vpn    (lk_vpn),
  .lk_acc    (lk_acc),
  .flush_all (flush_all),
  .rs_valid  (rs_valid),
  .rs_hit    (rs_hit),
  .rs_fault  (rs_fault),
  .rs_perm   (rs_perm),
  .wk_req    (wk_req),
  .wk_vpn    (wk_vpn),
  .hit_vec   (lk_hit_vec),
  .hv_all    (hv_q)
);

// File: tb/pair_tlb_test.sv
`timescale 1ns/1ps
module pair_tlb_test;
  localparam int ENT = 16;
  localparam int VW  = 20;
  localparam int PW  = 12;
  localparam int AW  = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          lk_valid, fl_valid, flush_all, flush_asid_en;
  logic [VW-1:0] lk_vpn, fl_vpn;
  logic [AW-1:0] lk_asid, fl_asid, flush_asid;
  logic [2:0]    lk_acc, fl_perm;
  logic [PW-1:0] fl_ppn;
  logic          rs_valid, rs_hit, rs_fault, wk_req;
  logic [PW-1:0] rs_ppn;
  logic [2:0]    rs_perm;
  logic [VW-1:0] wk_vpn;
  logic [AW-1:0] wk_asid;

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  done  = 0;

  // bench model of the entries
  bit            m_hv   [ENT][2];
  logic [VW-2:0] m_tag  [ENT];
  logic [AW-1:0] m_asid [ENT];
  logic [PW-1:0] m_ppn  [ENT][2];
  logic [2:0]    m_perm [ENT][2];
  int            m_rr;

  always #2.5 clk = ~clk;

  pair_tlb #(.ENTRIES(ENT), .VPN_W(VW), .PPN_W(PW), .ASID_W(AW)) uut (
    .clk(clk), .rst(rst),
    .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_asid(lk_asid), .lk_acc(lk_acc),
    .fl_valid(fl_valid), .fl_vpn(fl_vpn), .fl_asid(fl_asid), .fl_ppn(fl_ppn), .fl_perm(fl_perm),
    .flush_all(flush_all), .flush_asid_en(flush_asid_en), .flush_asid(flush_asid),
    .rs_valid(rs_valid), .rs_hit(rs_hit), .rs_fault(rs_fault), .rs_ppn(rs_ppn), .rs_perm(rs_perm),
    .wk_req(wk_req), .wk_vpn(wk_vpn), .wk_asid(wk_asid)
  );

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic chk(string r, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", r, what, act, exp);
    end
  endtask

  function automatic int m_lookup(logic [VW-1:0] v, logic [AW-1:0] a);
    for (int e = 0; e < ENT; e++)
      if (m_hv[e][v[0]] && m_tag[e] == v[VW-1:1] && m_asid[e] == a) return e;
    return -1;
  endfunction

  function automatic int m_pair(logic [VW-1:0] v, logic [AW-1:0] a);
    for (int e = 0; e < ENT; e++)
      if ((m_hv[e][0] || m_hv[e][1]) && m_tag[e] == v[VW-1:1] && m_asid[e] == a) return e;
    return -1;
  endfunction

  function automatic int m_free();
    for (int e = 0; e < ENT; e++)
      if (!m_hv[e][0] && !m_hv[e][1]) return e;
    return -1;
  endfunction

  task automatic m_apply();
    int e;
    if (flush_all) begin
      for (int i = 0; i < ENT; i++) begin m_hv[i][0] = 0; m_hv[i][1] = 0; end
    end else if (flush_asid_en) begin
      for (int i = 0; i < ENT; i++)
        if (m_asid[i] == flush_asid) begin m_hv[i][0] = 0; m_hv[i][1] = 0; end
    end else if (fl_valid) begin
      e = m_pair(fl_vpn, fl_asid);
      if (e < 0) begin
        e = m_free();
        if (e < 0) begin
          e = m_rr;
          m_rr = (m_rr + 1) % ENT;
        end
        m_hv[e][!fl_vpn[0]] = 0;
      end
      m_hv[e][fl_vpn[0]]   = 1;
      m_tag[e]             = fl_vpn[VW-1:1];
      m_asid[e]            = fl_asid;
      m_ppn[e][fl_vpn[0]]  = fl_ppn;
      m_perm[e][fl_vpn[0]] = fl_perm;
    end
  endtask

  task automatic idle();
    lk_valid = 0; lk_vpn = '0; lk_asid = '0; lk_acc = 3'b001;
    fl_valid = 0; fl_vpn = '0; fl_asid = '0; fl_ppn = '0; fl_perm = '0;
    flush_all = 0; flush_asid_en = 0; flush_asid = '0;
  endtask

  task automatic look(logic [VW-1:0] v, logic [AW-1:0] a, logic [2:0] acc);
    lk_valid = 1; lk_vpn = v; lk_asid = a; lk_acc = acc;
  endtask

  task automatic fill(logic [VW-1:0] v, logic [AW-1:0] a, logic [PW-1:0] p, logic [2:0] pm);
    fl_valid = 1; fl_vpn = v; fl_asid = a; fl_ppn = p; fl_perm = pm;
  endtask

  // one cycle: predict, update model, clock, compare
  task automatic tick(string r);
    int e;
    logic ev, eh, ef, er;
    logic [PW-1:0] ep;
    logic [2:0] epm;
    logic [VW-1:0] evpn;
    logic [AW-1:0] easid;
    e     = m_lookup(lk_vpn, lk_asid);
    ev    = lk_valid;
    eh    = lk_valid && e >= 0;
    ep    = eh ? m_ppn[e][lk_vpn[0]] : '0;
    epm   = eh ? m_perm[e][lk_vpn[0]] : 3'b000;
    ef    = eh && ((lk_acc & ~epm) != 3'b000);
    er    = lk_valid && e < 0;
    evpn  = lk_vpn;
    easid = lk_asid;
    m_apply();
    @(posedge clk);
    #1;
    chk(r, "rs_valid", 32'(rs_valid), 32'(ev));
    if (ev) begin
      chk(r, "rs_hit", 32'(rs_hit), 32'(eh));
      chk(r, "rs_ppn", 32'(rs_ppn), 32'(ep));
      chk(r, "rs_perm", 32'(rs_perm), 32'(epm));
      chk(r, "rs_fault", 32'(rs_fault), 32'(ef));
      chk(r, "wk_req", 32'(wk_req), 32'(er));
      if (er) begin
        chk(r, "wk_vpn", 32'(wk_vpn), 32'(evpn));
        chk(r, "wk_asid", 32'(wk_asid), 32'(easid));
      end
    end
    idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    idle();
    for (int e = 0; e < ENT; e++) begin m_hv[e][0] = 0; m_hv[e][1] = 0; end
    m_rr = 0;
    rst = 1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "rs_valid in reset", 32'(rs_valid), 32'd0);
    chk("R1", "wk_req in reset", 32'(wk_req), 32'd0);
    rst = 0;

    // R1/R4: first lookup after reset misses and asks for a walk
    look(20'h00010, 4'd1, 3'b001); tick("R1");
    tick("R2");
    // R11: lookup in the fill cycle still misses
    look(20'h00020, 4'd1, 3'b001); fill(20'h00020, 4'd1, 12'h0A1, 3'b011); tick("R11");
    look(20'h00020, 4'd1, 3'b001); tick("R3");
    look(20'h00021, 4'd1, 3'b001); tick("R7");
    chk("R7", "odd half after even fill", 32'(rs_hit), 32'd0);
    fill(20'h00021, 4'd1, 12'h0B2, 3'b100); tick("R7");
    look(20'h00020, 4'd1, 3'b010); tick("R7");
    chk("R7", "even half kept", 32'(rs_ppn), 32'h0A1);
    look(20'h00021, 4'd1, 3'b100); tick("R3");
    chk("R3", "odd half ppn", 32'(rs_ppn), 32'h0B2);
    look(20'h00020, 4'd2, 3'b001); tick("R5");
    look(20'h00021, 4'd1, 3'b001); tick("R6");
    chk("R6", "read on exec-only page", 32'(rs_fault), 32'd1);
    look(20'h00020, 4'd1, 3'b100); tick("R6");
    fill(20'h00020, 4'd2, 12'h0C3, 3'b111); tick("R5");
    look(20'h00020, 4'd2, 3'b111); tick("R5");
    chk("R5", "second identifier ppn", 32'(rs_ppn), 32'h0C3);
    flush_asid_en = 1; flush_asid = 4'd2; tick("R10");
    look(20'h00020, 4'd2, 3'b001); tick("R10");
    look(20'h00020, 4'd1, 3'b001); tick("R10");
    chk("R10", "other identifier survives", 32'(rs_hit), 32'd1);
    flush_all = 1; fill(20'h00030, 4'd1, 12'h0D4, 3'b001);
    look(20'h00020, 4'd1, 3'b001); tick("R11");
    chk("R11", "lookup in flush cycle sees old", 32'(rs_hit), 32'd1);
    look(20'h00020, 4'd1, 3'b001); tick("R9");
    chk("R9", "after flush", 32'(rs_hit), 32'd0);
    look(20'h00030, 4'd1, 3'b001); tick("R11");

    // R8: fill every entry, then replace in round-robin order
    for (int k = 0; k < ENT; k++) begin
      fill(20'h00100 + 20'(2 * k), 4'd3, 12'h100 + 12'(k), 3'b001); tick("R8");
    end
    fill(20'h00101, 4'd3, 12'h1FF, 3'b001); tick("R7");
    fill(20'h00200, 4'd3, 12'h200, 3'b001); tick("R8");
    look(20'h00100, 4'd3, 3'b001); tick("R8");
    chk("R8", "first pair evicted", 32'(rs_hit), 32'd0);
    look(20'h00201, 4'd3, 3'b001); tick("R7");
    chk("R7", "other half cleared on new tag", 32'(rs_hit), 32'd0);
    look(20'h00102, 4'd3, 3'b001); tick("R8");
    fill(20'h00202, 4'd3, 12'h202, 3'b001); tick("R8");
    look(20'h00102, 4'd3, 3'b001); tick("R8");
    chk("R8", "second pair evicted", 32'(rs_hit), 32'd0);
    look(20'h00104, 4'd3, 3'b001); tick("R8");
    chk("R8", "third pair kept", 32'(rs_hit), 32'd1);

    // random mix checked against the model (R3, R5, R6, R7, R8, R10, R12)
    for (int i = 0; i < 4000; i++) begin
      if ($urandom % 4 != 0)
        look(20'($urandom % 48), 4'($urandom % 3), 3'(1 + $urandom % 7));
      if ($urandom % 3 == 0)
        fill(20'($urandom % 48), 4'($urandom % 3), 12'($urandom), 3'($urandom));
      if ($urandom % 300 == 0) flush_all = 1;
      if ($urandom % 150 == 0) begin flush_asid_en = 1; flush_asid = 4'($urandom % 3); end
      tick("R3");
    end

    done = 1;
    summary();
    $finish;
  end
endmodule